// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Break, Echo and Clear-to-Send Gating

This block turns bytes written by a host into framed asynchronous serial characters on a single NRZ line. A byte lands in a holding register. When the line is free and the modem permits it, the byte moves into a shift register and goes out as one start bit, five to eight data bits (least significant first), an optional parity bit and a stop period. The stop period can be one, one and a half or two bit times. Bit timing comes from a clock-enable pulse that the surrounding logic supplies at sixteen times the bit rate. The block does no rate division of its own.

Several line behaviours sit on top of plain framing. An active-low clear-to-send input holds back new characters but always lets the current one finish. A break selection sends characters made entirely of space, and when break is dropped a single mark stop bit follows. An echo selection drives the output with the receive line delayed by half a bit. A terminal-ready input shuts the transmitter off at once. A holding-register-empty flag tells the host when it may write the next byte.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, and whenever no character is being sent, `txd` is 1 (mark) and `thr_empty` is 1.
- R2: Each transmitted bit lasts 16 `tick` pulses. The data field carries `word_len`+5 bits (code 00 gives 5 bits, 11 gives 8), least significant bit first. Holding-register bits above the word length affect neither the data field nor the parity bit.
- R3: With `par_en`=1 a parity bit follows the data. `par_mode` 00 makes the count of ones in data plus parity odd, 01 makes it even, 10 sends a constant 1 and 11 sends a constant 0. With `par_en`=0 no parity bit is sent.
- R4: With `stop_sel`=0 the stop period is 16 ticks. With `stop_sel`=1 it is 24 ticks for 5-bit words without parity, 16 ticks for 8-bit words with parity, and 32 ticks in every other case.
- R5: `thr_empty` goes to 1 in the cycle after the start bit of a byte begins, when that byte leaves the holding register. It goes to 0 in the cycle after a host write (`wr_en`=1).
- R6: A byte that waits in the holding register at the end of a stop period starts its start bit right away, with no gap. A byte written while the line is idle starts its start bit two cycles after the write cycle.
- R7: While `cts_n` is 1 no new character starts and the holding register keeps its byte. A character already under way finishes all of its bits. Transmission resumes within a few cycles after `cts_n` returns to 0.
- R8: With `tx_ctrl`=11, characters of all-space (start, data, parity and stop all 0) are sent from the next character boundary onward, and they do not take the holding-register byte. A break character that has begun always completes. When `tx_ctrl` is no longer 11 at the end of a break character, one 16-tick mark stop bit follows, and after it normal transmission resumes. No other `tx_ctrl` value changes framing.
- R9: With `echo_en`=1 the framer starts no characters and `txd` follows `rxd` delayed by 8 ticks. While `cts_n` is 1, `txd` is 1 from the same cycle on.
- R10: With `dtr`=0, `txd` is 1 in the same cycle. The character under way is abandoned and does not resume when `dtr` returns to 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Clock enable, 16 pulses per bit time |
| wr_en | input | 1 | Host write strobe for the holding register |
| wr_data | input | 8 | Byte written by the host |
| word_len | input | 2 | Word length code, bits = code + 5 |
| par_en | input | 1 | Parity bit enable |
| par_mode | input | 2 | Parity kind: odd, even, constant 1, constant 0 |
| stop_sel | input | 1 | Stop period select |
| tx_ctrl | input | 2 | Transmit control; 11 selects continuous break |
| echo_en | input | 1 | Retransmit the receive line with a half-bit delay |
| dtr | input | 1 | Terminal ready; 0 turns the transmitter off |
| cts_n | input | 1 | Clear to send, active low |
| rxd | input | 1 | Receive line, used in echo mode |
| txd | output | 1 | Serial output, 1 = mark |
| thr_empty | output | 1 | Holding register is free for a new byte |

## Verification
On every cycle the assertions check four things: the empty flag follows writes and loads, a load is followed at once by a space on the line, no character starts while clear-to-send is withheld, and a dropped terminal-ready leaves the framer idle by the next cycle. Other behaviours can only be shown by the bench's scenarios: the bit order, the parity values, the stop-period lengths measured between back-to-back characters, a break that outlasts its request and ends with its extra stop bit, and the half-bit echo delay.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

  localparam int TX_DW = 8;

  typedef enum logic [2:0] {
    S_IDLE,
    S_START,
    S_DATA,
    S_PAR,
    S_STOP,
    S_BRK_STOP
  } tx_state_e;

  localparam logic [1:0] TXC_BREAK = 2'b11;

  // index of the last data bit for a word length code (5..8 bits)
  function automatic logic [2:0] last_bit_idx(input logic [1:0] wl);
    return 3'd4 + {1'b0, wl};
  endfunction

  function automatic logic parity_of(input logic [TX_DW-1:0] d,
                                     input logic [1:0] wl,
                                     input logic [1:0] pm);
    logic [TX_DW-1:0] m;
    m = d & (8'hFF >> (2'd3 - wl));
    case (pm)
      2'b00:   return ~(^m);
      2'b01:   return ^m;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // stop period length in ticks
  function automatic int stop_len(input logic ss, input logic [1:0] wl,
                                  input logic pe, input int tpb);
    if (!ss) return tpb;
    if (wl == 2'd0 && !pe) return tpb + tpb / 2;
    if (wl == 2'd3 && pe) return tpb;
    return 2 * tpb;
  endfunction

endpackage

// File: rtl/uart_tx_holding.sv
module uart_tx_holding #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          take,
  output logic [DW-1:0] thr,
  output logic          thr_empty
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      thr       <= '0;
      thr_empty <= 1'b1;
    end else if (wr_en) begin
      thr       <= wr_data;
      thr_empty <= 1'b0;
    end else if (take) begin
      thr_empty <= 1'b1;
    end
  end
endmodule

// File: rtl/uart_tx_echo.sv
module uart_tx_echo #(
  parameter int DEPTH = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic rxd,
  output logic dly
);
  logic [DEPTH-1:0] line_q;

  always_ff @(posedge clk) begin
    if (!rst_n)    line_q <= '1;
    else if (tick) line_q <= {line_q[DEPTH-2:0], rxd};
  end

  assign dly = line_q[DEPTH-1];
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
#(
  parameter int TPB = 16,
  parameter int CW  = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             dtr,
  input  logic             cts_n,
  input  logic             echo_en,
  input  logic             brk_req,
  input  logic [1:0]       wl,
  input  logic             par_en,
  input  logic [1:0]       par_mode,
  input  logic             stop_sel,
  input  logic [TX_DW-1:0] thr,
  input  logic             thr_empty,
  output logic             load_evt,
  output logic             char_start,
  output logic             busy,
  output logic             txd
);
  tx_state_e        state;
  logic [CW-1:0]    cnt;
  logic [2:0]       bitn;
  logic [TX_DW-1:0] shreg;
  logic             parbit;
  logic             brk_char;

  logic can_go, go_brk, go_data, bit_done, char_end, at_bound, start_ok;
  int   limit;

  assign can_go  = dtr && !cts_n && !echo_en;
  assign go_brk  = can_go && brk_req;
  assign go_data = can_go && !brk_req && !thr_empty;

  always_comb limit = (state == S_STOP) ? stop_len(stop_sel, wl, par_en, TPB) : TPB;

  assign bit_done = tick && (int'(cnt) == limit - 1);
  assign char_end = (state == S_STOP) && bit_done;
  assign at_bound = (state == S_IDLE) || char_end ||
                    ((state == S_BRK_STOP) && bit_done);
  assign start_ok = at_bound && (go_brk || go_data) &&
                    !(char_end && brk_char && !brk_req);

  assign char_start = start_ok;
  assign load_evt   = start_ok && !go_brk;
  assign busy       = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      bitn     <= '0;
      shreg    <= '0;
      parbit   <= 1'b0;
      brk_char <= 1'b0;
    end else if (!dtr) begin
      state    <= S_IDLE;
      cnt      <= '0;
      brk_char <= 1'b0;
    end else if (start_ok) begin
      state    <= S_START;
      cnt      <= '0;
      brk_char <= go_brk;
      if (!go_brk) begin
        shreg  <= thr;
        parbit <= parity_of(thr, wl, par_mode);
      end
    end else begin
      case (state)
        S_START: begin
          if (bit_done) begin
            state <= S_DATA;
            cnt   <= '0;
            bitn  <= '0;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        S_DATA: begin
          if (bit_done) begin
            cnt <= '0;
            if (bitn == last_bit_idx(wl)) begin
              state <= par_en ? S_PAR : S_STOP;
            end else begin
              bitn  <= bitn + 1'b1;
              shreg <= shreg >> 1;
            end
          end else if (tick) cnt <= cnt + 1'b1;
        end
        S_PAR: begin
          if (bit_done) begin
            state <= S_STOP;
            cnt   <= '0;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        S_STOP: begin
          if (bit_done) begin
            state    <= (brk_char && !brk_req) ? S_BRK_STOP : S_IDLE;
            cnt      <= '0;
            brk_char <= 1'b0;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        S_BRK_STOP: begin
          if (bit_done) begin
            state <= S_IDLE;
            cnt   <= '0;
          end else if (tick) cnt <= cnt + 1'b1;
        end
        default: cnt <= '0;
      endcase
    end
  end

  always_comb begin
    case (state)
      S_START: txd = 1'b0;
      S_DATA:  txd = brk_char ? 1'b0 : shreg[0];
      S_PAR:   txd = brk_char ? 1'b0 : parbit;
      S_STOP:  txd = !brk_char;
      default: txd = 1'b1;
    endcase
  end
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int TPB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             wr_en,
  input  logic [TX_DW-1:0] wr_data,
  input  logic [1:0]       word_len,
  input  logic             par_en,
  input  logic [1:0]       par_mode,
  input  logic             stop_sel,
  input  logic [1:0]       tx_ctrl,
  input  logic             echo_en,
  input  logic             dtr,
  input  logic             cts_n,
  input  logic             rxd,
  output logic             txd,
  output logic             thr_empty
);
  localparam int HALF = TPB / 2;
  localparam int CW   = $clog2(2 * TPB + 1);

  logic [TX_DW-1:0] thr;
  logic load_evt, char_start, busy, frm_txd, echo_bit;

  uart_tx_holding #(.DW(TX_DW)) u_hold (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(load_evt), .thr(thr), .thr_empty(thr_empty)
  );

  uart_tx_framer #(.TPB(TPB), .CW(CW)) u_frm (
    .clk(clk), .rst_n(rst_n), .tick(tick), .dtr(dtr), .cts_n(cts_n),
    .echo_en(echo_en), .brk_req(tx_ctrl == TXC_BREAK), .wl(word_len),
    .par_en(par_en), .par_mode(par_mode), .stop_sel(stop_sel),
    .thr(thr), .thr_empty(thr_empty), .load_evt(load_evt),
    .char_start(char_start), .busy(busy), .txd(frm_txd)
  );

  uart_tx_echo #(.DEPTH(HALF)) u_echo (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rxd(rxd), .dly(echo_bit)
  );

  always_comb begin
    if (!dtr)         txd = 1'b1;
    else if (echo_en) txd = cts_n | echo_bit;
    else              txd = frm_txd;
  end
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic thr_empty,
  input logic txd,
  input logic dtr,
  input logic echo_en,
  input logic cts_n,
  input logic load_evt,
  input logic char_start,
  input logic busy
);
  p_write_clears_r5: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !thr_empty);

  p_load_sets_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !wr_en) |=> thr_empty);

  p_start_space_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (!txd || !dtr || echo_en));

  p_cts_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    char_start |-> !cts_n);

  p_dtr_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !dtr |=> !busy);

  p_idle_mark_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !echo_en) |-> txd);
endmodule

bind uart_tx_core uart_tx_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .thr_empty(thr_empty),
  .txd(txd), .dtr(dtr), .echo_en(echo_en), .cts_n(cts_n),
  .load_evt(load_evt), .char_start(char_start), .busy(busy)
);

// File: tb/uart_tx_core_tb.sv
`timescale 1ns/1ps
module uart_tx_core_tb;
  logic       clk = 0, rst_n = 0, tick = 0, wr_en = 0;
  logic [7:0] wr_data = 0;
  logic [1:0] word_len = 2'd3, par_mode = 0, tx_ctrl = 0;
  logic       par_en = 0, stop_sel = 0, echo_en = 0, dtr = 1, cts_n = 0, rxd = 1;
  wire        txd, thr_empty;

  int cyc = 0, checks = 0, fails = 0;
  bit done = 0;

  uart_tx_core u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
    .word_len(word_len), .par_en(par_en), .par_mode(par_mode),
    .stop_sel(stop_sel), .tx_ctrl(tx_ctrl), .echo_en(echo_en), .dtr(dtr),
    .cts_n(cts_n), .rxd(rxd), .txd(txd), .thr_empty(thr_empty)
  );

  always #2.5 clk = ~clk;
  always @(negedge clk) tick <= ~tick;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 150000 && !done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d expected <150000 cycles", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  // {stop_sel, par_mode[1:0], par_en, word_len[1:0], data[7:0]}
  localparam logic [13:0] VEC [8] = '{
    {1'b0, 2'b00, 1'b0, 2'b11, 8'hA5},
    {1'b1, 2'b00, 1'b0, 2'b00, 8'h3C},
    {1'b1, 2'b00, 1'b1, 2'b11, 8'h81},
    {1'b1, 2'b01, 1'b1, 2'b10, 8'h5A},
    {1'b0, 2'b10, 1'b1, 2'b01, 8'hFF},
    {1'b1, 2'b11, 1'b1, 2'b00, 8'h0F},
    {1'b1, 2'b00, 1'b0, 2'b01, 8'hC3},
    {1'b0, 2'b00, 1'b1, 2'b00, 8'hE7}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  task automatic goto(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic write_byte(input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic wait_fall(output int t);
    int lim;
    lim = cyc + 3000;
    while (txd !== 1'b0 && cyc < lim) @(negedge clk);
    t = cyc;
    if (txd !== 1'b0) chk(0, "R6 start bit seen", 1, 0);
  endtask

  function automatic bit ref_par(input logic [7:0] d, input int n, input logic [1:0] pm);
    int ones;
    ones = 0;
    for (int i = 0; i < n; i++) ones += d[i];
    case (pm)
      2'b00:   return (ones % 2) == 0;
      2'b01:   return (ones % 2) == 1;
      2'b10:   return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  // stop period in half-bit units
  function automatic int ref_stop_half(input bit ss, input int n, input bit pe);
    if (!ss) return 2;
    if (n == 5 && !pe) return 3;
    if (n == 8 && pe) return 2;
    return 4;
  endfunction

  initial begin
    int t0, t1, rc, n, p, fr;
    logic [7:0] a;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(txd === 1'b1, "R1 txd in reset", txd, 1);
    chk(thr_empty === 1'b1, "R1 thr_empty in reset", thr_empty, 1);
    rst_n = 1;
    goto(cyc + 20);
    chk(txd === 1'b1, "R1 idle mark", txd, 1);

    // vector walk: R2 R3 R4 R5 R6
    for (int v = 0; v < 8; v++) begin
      a = VEC[v][7:0];
      @(negedge clk);
      word_len = VEC[v][9:8]; par_en = VEC[v][10];
      par_mode = VEC[v][12:11]; stop_sel = VEC[v][13];
      n  = int'(VEC[v][9:8]) + 5;
      p  = par_en ? 1 : 0;
      fr = ((1 + n + p) * 2 + ref_stop_half(stop_sel, n, par_en)) * 16;
      write_byte(a);
      wait_fall(t0);
      chk(thr_empty === 1'b1, "R5 empty after load", thr_empty, 1);
      write_byte(~a);
      chk(thr_empty === 1'b0, "R5 cleared by write", thr_empty, 0);
      goto(t0 + 16);
      chk(txd === 1'b0, "R2 start bit", txd, 0);
      for (int k = 0; k < n; k++) begin
        goto(t0 + 16 + 32 * (k + 1));
        chk(txd === a[k], "R2 data bit", txd, a[k]);
      end
      if (p != 0) begin
        goto(t0 + 16 + 32 * (n + 1));
        chk(txd === ref_par(a, n, par_mode), "R3 parity bit", txd,
            ref_par(a, n, par_mode));
      end
      goto(t0 + 16 + 32 * (n + 1 + p));
      chk(txd === 1'b1, "R4 stop mark", txd, 1);
      wait_fall(t1);
      chk((t1 - t0) >= fr - 2 && (t1 - t0) <= fr + 2, "R4 R6 frame length", t1 - t0, fr);
      goto(t1 + 700);
    end

    @(negedge clk);
    word_len = 2'd3; par_en = 0; stop_sel = 0; par_mode = 0;

    // R7: clear-to-send gating
    cts_n = 1;
    write_byte(8'h96);
    goto(cyc + 100);
    chk(txd === 1'b1, "R7 held while cts high", txd, 1);
    chk(thr_empty === 1'b0, "R7 byte kept", thr_empty, 0);
    rc = cyc; cts_n = 0;
    wait_fall(t0);
    chk(t0 - rc <= 3, "R7 resume delay", t0 - rc, 3);
    write_byte(8'h11);
    goto(t0 + 100); cts_n = 1;
    goto(t0 + 240);
    chk(txd === 1'b0, "R7 char finishes bit6", txd, 0);
    goto(t0 + 272);
    chk(txd === 1'b1, "R7 char finishes bit7", txd, 1);
    goto(t0 + 304);
    chk(txd === 1'b1, "R7 stop sent", txd, 1);
    goto(t0 + 500);
    chk(txd === 1'b1, "R7 next char held", txd, 1);
    chk(thr_empty === 1'b0, "R7 next byte kept", thr_empty, 0);
    rc = cyc; cts_n = 0;
    wait_fall(t1);
    chk(t1 - rc <= 3, "R7 second resume", t1 - rc, 3);
    goto(t1 + 700);

    // R8: break
    @(negedge clk); tx_ctrl = 2'b11;
    wait_fall(t0);
    write_byte(8'h55);
    goto(t0 + 20); tx_ctrl = 2'b00;
    goto(t0 + 100);
    chk(txd === 1'b0, "R8 break space early", txd, 0);
    goto(t0 + 200);
    chk(thr_empty === 1'b0, "R8 break leaves byte", thr_empty, 0);
    goto(t0 + 300);
    chk(txd === 1'b0, "R8 full break char", txd, 0);
    goto(t0 + 336);
    chk(txd === 1'b1, "R8 stop after break", txd, 1);
    wait_fall(t1);
    chk((t1 - t0) >= 350 && (t1 - t0) <= 354, "R8 resume after stop", t1 - t0, 352);
    goto(t1 + 700);

    // R10: terminal ready off
    write_byte(8'h00);
    wait_fall(t0);
    goto(t0 + 100); dtr = 0;
    goto(t0 + 101);
    chk(txd === 1'b1, "R10 immediate mark", txd, 1);
    goto(t0 + 200);
    chk(txd === 1'b1, "R10 stays mark", txd, 1);
    dtr = 1;
    goto(t0 + 300);
    chk(txd === 1'b1, "R10 no resume", txd, 1);
    chk(thr_empty === 1'b1, "R10 empty flag", thr_empty, 1);

    // R9: echo
    echo_en = 1;
    goto(cyc + 40);
    chk(txd === 1'b1, "R9 echo idle", txd, 1);
    rc = cyc; rxd = 0;
    goto(rc + 8);
    chk(txd === 1'b1, "R9 echo not early", txd, 1);
    goto(rc + 24);
    chk(txd === 1'b0, "R9 echo delayed space", txd, 0);
    goto(rc + 60); rxd = 1;
    goto(rc + 68);
    chk(txd === 1'b0, "R9 echo holds", txd, 0);
    goto(rc + 84);
    chk(txd === 1'b1, "R9 echo delayed mark", txd, 1);
    goto(rc + 120); rxd = 0;
    goto(rc + 150);
    chk(txd === 1'b0, "R9 echo space again", txd, 0);
    cts_n = 1;
    goto(rc + 151);
    chk(txd === 1'b1, "R9 cts forces mark", txd, 1);
    echo_en = 0; cts_n = 0; rxd = 1;
    goto(cyc + 20);
    chk(txd === 1'b1, "R1 idle after echo", txd, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule